// File: doc/BRIEF.md
# Segment Register Load Checker

This block sits in the execute stage of a protected-mode processor model and judges every request to place a new selector into one of six segment registers. The request carries the target register, the 16-bit selector, the current privilege level, the attribute fields of the descriptor that the selector names, and the descriptor table limit. The table lookup itself happens upstream. Within one cycle the block decides whether to commit the selector and its descriptor attributes to the register bank, or to report one fault together with an error code.

The stack segment register and the four data segment registers follow different admission rules. Null selectors have their own handling: they are refused for the stack register and accepted for the data registers. A later memory reference through a data register that holds a null selector is flagged. A successful stack-register load raises a one-instruction interrupt-inhibit flag. Loads aimed at the code segment register, or at an unused register code, are rejected as invalid opcodes.

Top module: `segld_top`

## Requirements
- R1: After reset all six registers hold selector 0 and attribute byte 0, `done` and `int_inhibit` are low, and `fault` is 0.
- R2: A request sampled at a clock edge yields its result on the outputs after that edge. `done` is high for exactly that one cycle and `fault` holds one class: 0 none, 1 general protection, 2 stack, 3 not present, 4 invalid opcode. `done` is low with `fault` 0 when no request was made.
- R3: A selector is null when bits 15:2 are zero. A null selector aimed at register 0, 3, 4 or 5 commits with no fault and writes attribute byte 0.
- R4: A reference (`ref_valid`, `ref_seg`) through a register that holds a null selector sets `ref_fault` one cycle later. A reference through a register with a non-null selector leaves `ref_fault` low.
- R5: A null selector aimed at the stack register (code 2) gives a general-protection fault with error code 0.
- R6: A non-null stack-register load gives a general-protection fault with the selector as its error code when any of the following holds: the limit check fails, RPL (bits 1:0) differs from CPL, the descriptor is not a writable data segment, or DPL differs from CPL.
- R7: A stack-register load that passes R6 but whose present bit is 0 gives a stack fault with the selector as its error code.
- R8: A non-null data-register load gives a general-protection fault with the selector as its error code when any of the following holds: the limit check fails, the descriptor is neither data nor readable code, or the descriptor is data or nonconforming code and RPL or CPL exceeds DPL. Descriptor kind bits: bit 3 = code, bit 2 = conforming (code), bit 1 = writable (data) or readable (code). `desc_sys_n` = 1 marks a code or data descriptor.
- R9: A data-register load that passes R8 but whose present bit is 0 gives a not-present fault with the selector as its error code.
- R10: A request aimed at the code register (code 1) or at codes 6 and 7 gives an invalid-opcode fault with error code 0 and writes nothing.
- R11: The limit check fails when {selector[15:3], 3'b111} is greater than `tbl_limit`. When the two are equal the check passes.
- R12: The checks run in the order null, then limit, privilege and type, then presence, and only the first failing check is reported. A faulting request leaves every register unchanged.
- R13: A committed stack-register load sets `int_inhibit` after its edge. `insn_retire` or `exc_deliver` clears it at the next edge. A committed stack load in the same cycle as a clear keeps the flag set.
- R14: A committed non-null load stores the selector and the attribute byte {present, DPL[1:0], sys_n, kind[3:0]}. The stored values are readable through `view_seg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Load request this cycle |
| req_seg | input | 3 | Target register: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| req_sel | input | 16 | Selector to load |
| cpl | input | 2 | Current privilege level |
| desc_sys_n | input | 1 | 1 = code or data descriptor |
| desc_kind | input | 4 | Descriptor type bits |
| desc_dpl | input | 2 | Descriptor privilege level |
| desc_present | input | 1 | Descriptor present bit |
| tbl_limit | input | 16 | Descriptor table limit in bytes |
| insn_retire | input | 1 | Next instruction retired |
| exc_deliver | input | 1 | Exception delivered |
| ref_valid | input | 1 | Memory reference through a segment register |
| ref_seg | input | 3 | Register used by the reference |
| view_seg | input | 3 | Register shown on the view outputs |
| done | output | 1 | Result valid |
| fault | output | 3 | Fault class |
| fault_code | output | 16 | Error code |
| view_sel | output | 16 | Committed selector of `view_seg` |
| view_attr | output | 8 | Committed attribute byte of `view_seg` |
| int_inhibit | output | 1 | Interrupt inhibit for one instruction boundary |
| ref_fault | output | 1 | Reference through a null register |

## Verification
A load request driven before edge N shows its `done`, `fault` and `fault_code` after edge N, and its committed selector and attributes appear on the view port after that same edge. The bench drives each request on a falling edge and samples on the next falling edge. It then checks that `done` has fallen one cycle later. `int_inhibit` is sampled on the falling edge after the setting load, and again one edge after a retire or delivery pulse. `ref_fault` is sampled one falling edge after the reference is driven. Each refused load is followed by a read of the target register, which confirms that nothing was written.

// File: rtl/segld_pkg.sv
package segld_pkg;
    localparam int SEL_W  = 16;
    localparam int NSEG   = 6;
    localparam int IDX_W  = 3;
    localparam int PL_W   = 2;

    typedef enum logic [2:0] {
        FLT_NONE  = 3'd0,
        FLT_GP    = 3'd1,
        FLT_STACK = 3'd2,
        FLT_NOTP  = 3'd3,
        FLT_UD    = 3'd4
    } fault_e;

    localparam logic [IDX_W-1:0] SEG_ES = 3'd0;
    localparam logic [IDX_W-1:0] SEG_CS = 3'd1;
    localparam logic [IDX_W-1:0] SEG_SS = 3'd2;
    localparam logic [IDX_W-1:0] SEG_DS = 3'd3;
    localparam logic [IDX_W-1:0] SEG_FS = 3'd4;
    localparam logic [IDX_W-1:0] SEG_GS = 3'd5;

    typedef struct packed {
        logic            present;
        logic [PL_W-1:0] dpl;
        logic            sys_n;
        logic [3:0]      kind;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);
endpackage

// File: rtl/segld_sel_fields.sv
module segld_sel_fields #(
    parameter int SEL_W = 16
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [SEL_W-1:0] limit,
    output logic             is_null,
    output logic [1:0]       rpl,
    output logic             over_limit
);
    logic [SEL_W-1:0] last_byte;

    always_comb begin
        is_null    = (sel[SEL_W-1:2] == '0);
        rpl        = sel[1:0];
        last_byte  = {sel[SEL_W-1:3], 3'b111};
        over_limit = (last_byte > limit);
    end
endmodule

// File: rtl/segld_rules.sv
module segld_rules
    import segld_pkg::*;
#(
    parameter int SEL_W = 16,
    parameter int IDX_W = 3
) (
    input  logic [IDX_W-1:0] seg,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       cpl,
    input  attr_t            attr,
    input  logic             is_null,
    input  logic [1:0]       rpl,
    input  logic             over_limit,
    output fault_e           fault,
    output logic [SEL_W-1:0] code,
    output logic             wr_en,
    output attr_t            wr_attr,
    output logic             set_inhibit
);
    logic is_data, is_code, writable, rd_code, conforming, data_seg;

    always_comb begin
        is_data    = attr.sys_n & ~attr.kind[3];
        is_code    = attr.sys_n &  attr.kind[3];
        writable   = is_data & attr.kind[1];
        rd_code    = is_code & attr.kind[1];
        conforming = is_code & attr.kind[2];
        data_seg   = (seg == SEG_ES) || (seg == SEG_DS) ||
                     (seg == SEG_FS) || (seg == SEG_GS);

        fault       = FLT_NONE;
        code        = '0;
        wr_en       = 1'b0;
        wr_attr     = attr;
        set_inhibit = 1'b0;

        if (seg == SEG_SS) begin
            if (is_null) begin
                fault = FLT_GP;
            end else if (over_limit || (rpl != cpl) || !writable ||
                         (attr.dpl != cpl)) begin
                fault = FLT_GP;
                code  = sel;
            end else if (!attr.present) begin
                fault = FLT_STACK;
                code  = sel;
            end else begin
                wr_en       = 1'b1;
                set_inhibit = 1'b1;
            end
        end else if (data_seg) begin
            if (is_null) begin
                wr_en   = 1'b1;
                wr_attr = '0;
            end else if (over_limit || !(is_data || rd_code) ||
                         ((is_data || (is_code && !conforming)) &&
                          ((rpl > attr.dpl) || (cpl > attr.dpl)))) begin
                fault = FLT_GP;
                code  = sel;
            end else if (!attr.present) begin
                fault = FLT_NOTP;
                code  = sel;
            end else begin
                wr_en = 1'b1;
            end
        end else begin
            fault = FLT_UD;
        end
    end
endmodule

// File: rtl/segld_bank.sv
module segld_bank #(
    parameter int NSEG   = 6,
    parameter int SEL_W  = 16,
    parameter int ATTR_W = 8,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [ATTR_W-1:0] wr_attr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [SEL_W-1:0]  rd_sel,
    output logic [ATTR_W-1:0] rd_attr,
    output logic [NSEG-1:0]   null_vec
);
    logic [NSEG-1:0][SEL_W-1:0]  sel_d, sel_q;
    logic [NSEG-1:0][ATTR_W-1:0] attr_d, attr_q;

    always_comb begin
        for (int i = 0; i < NSEG; i++) begin
            sel_d[i]  = sel_q[i];
            attr_d[i] = attr_q[i];
            if (we && (int'(wr_idx) == i)) begin
                sel_d[i]  = wr_sel;
                attr_d[i] = wr_attr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            attr_q <= '0;
        end else begin
            sel_q  <= sel_d;
            attr_q <= attr_d;
        end
    end

    for (genvar gi = 0; gi < NSEG; gi++) begin : g_null
        assign null_vec[gi] = (sel_q[gi][SEL_W-1:2] == '0);
    end

    always_comb begin
        rd_sel  = '0;
        rd_attr = '0;
        if (int'(rd_idx) < NSEG) begin
            rd_sel  = sel_q[rd_idx];
            rd_attr = attr_q[rd_idx];
        end
    end

    // R12: without a write strobe the bank holds its contents
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> ($stable(sel_q) && $stable(attr_q)));
endmodule

// File: rtl/segld_top.sv
module segld_top
    import segld_pkg::*;
#(
    parameter int SEL_W = segld_pkg::SEL_W,
    parameter int NSEG  = segld_pkg::NSEG,
    parameter int IDX_W = segld_pkg::IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [IDX_W-1:0]  req_seg,
    input  logic [SEL_W-1:0]  req_sel,
    input  logic [1:0]        cpl,
    input  logic              desc_sys_n,
    input  logic [3:0]        desc_kind,
    input  logic [1:0]        desc_dpl,
    input  logic              desc_present,
    input  logic [SEL_W-1:0]  tbl_limit,
    input  logic              insn_retire,
    input  logic              exc_deliver,
    input  logic              ref_valid,
    input  logic [IDX_W-1:0]  ref_seg,
    input  logic [IDX_W-1:0]  view_seg,
    output logic              done,
    output logic [2:0]        fault,
    output logic [SEL_W-1:0]  fault_code,
    output logic [SEL_W-1:0]  view_sel,
    output logic [ATTR_W-1:0] view_attr,
    output logic              int_inhibit,
    output logic              ref_fault
);
    typedef struct packed {
        logic             done;
        fault_e           fault;
        logic [SEL_W-1:0] code;
        logic             inhibit;
        logic             ref_fault;
    } state_t;

    state_t st_d, st_q;

    attr_t            req_attr, wr_attr;
    logic             is_null, over_limit, wr_en, set_inhibit;
    logic [1:0]       rpl;
    fault_e           chk_fault;
    logic [SEL_W-1:0] chk_code;
    logic [NSEG-1:0]  null_vec;

    assign req_attr = '{present: desc_present, dpl: desc_dpl,
                        sys_n: desc_sys_n, kind: desc_kind};

    segld_sel_fields #(.SEL_W(SEL_W)) u_fields (
        .sel        (req_sel),
        .limit      (tbl_limit),
        .is_null    (is_null),
        .rpl        (rpl),
        .over_limit (over_limit)
    );

    segld_rules #(.SEL_W(SEL_W), .IDX_W(IDX_W)) u_rules (
        .seg         (req_seg),
        .sel         (req_sel),
        .cpl         (cpl),
        .attr        (req_attr),
        .is_null     (is_null),
        .rpl         (rpl),
        .over_limit  (over_limit),
        .fault       (chk_fault),
        .code        (chk_code),
        .wr_en       (wr_en),
        .wr_attr     (wr_attr),
        .set_inhibit (set_inhibit)
    );

    segld_bank #(.NSEG(NSEG), .SEL_W(SEL_W), .ATTR_W(ATTR_W), .IDX_W(IDX_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (req_valid && wr_en),
        .wr_idx   (req_seg),
        .wr_sel   (req_sel),
        .wr_attr  (wr_attr),
        .rd_idx   (view_seg),
        .rd_sel   (view_sel),
        .rd_attr  (view_attr),
        .null_vec (null_vec)
    );

    always_comb begin
        st_d           = st_q;
        st_d.done      = req_valid;
        st_d.fault     = req_valid ? chk_fault : FLT_NONE;
        st_d.code      = req_valid ? chk_code : '0;
        if (req_valid && set_inhibit) begin
            st_d.inhibit = 1'b1;
        end else if (insn_retire || exc_deliver) begin
            st_d.inhibit = 1'b0;
        end
        st_d.ref_fault = ref_valid && (int'(ref_seg) < NSEG) && null_vec[ref_seg];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{done: 1'b0, fault: FLT_NONE, code: '0,
                      inhibit: 1'b0, ref_fault: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign done        = st_q.done;
    assign fault       = st_q.fault;
    assign fault_code  = st_q.code;
    assign int_inhibit = st_q.inhibit;
    assign ref_fault   = st_q.ref_fault;

    // R2: one result per request, reported after the sampling edge
    p_result_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> done);
    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!done && fault == FLT_NONE));

    // R5: null stack selector reports general protection with code zero
    p_ss_null_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_seg == SEG_SS && req_sel[SEL_W-1:2] == '0)
        |=> (fault == FLT_GP && fault_code == '0));

    // R10: code register target is an invalid opcode
    p_cs_ud_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_seg == SEG_CS) |=> (fault == FLT_UD && fault_code == '0));

    // R13: inhibit only rises after a stack-register request
    p_inhibit_src_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(int_inhibit) |-> $past(req_valid && req_seg == SEG_SS));
    p_inhibit_clear_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (int_inhibit && (insn_retire || exc_deliver) &&
         !(req_valid && req_seg == SEG_SS)) |=> !int_inhibit);
endmodule

// File: tb/segld_top_tb.sv
module segld_top_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_seg = '0;
    logic [15:0] req_sel = '0;
    logic [1:0]  cpl = '0;
    logic        desc_sys_n = 1'b0;
    logic [3:0]  desc_kind = '0;
    logic [1:0]  desc_dpl = '0;
    logic        desc_present = 1'b0;
    logic [15:0] tbl_limit = '0;
    logic        insn_retire = 1'b0;
    logic        exc_deliver = 1'b0;
    logic        ref_valid = 1'b0;
    logic [2:0]  ref_seg = '0;
    logic [2:0]  view_seg = '0;
    logic        done;
    logic [2:0]  fault;
    logic [15:0] fault_code;
    logic [15:0] view_sel;
    logic [7:0]  view_attr;
    logic        int_inhibit;
    logic        ref_fault;

    int n_tests = 0;
    int n_fail  = 0;

    localparam logic [2:0] F_NONE = 3'd0, F_GP = 3'd1, F_STK = 3'd2,
                           F_NP = 3'd3, F_UD = 3'd4;

    segld_top u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_seg(req_seg),
        .req_sel(req_sel), .cpl(cpl), .desc_sys_n(desc_sys_n),
        .desc_kind(desc_kind), .desc_dpl(desc_dpl), .desc_present(desc_present),
        .tbl_limit(tbl_limit), .insn_retire(insn_retire), .exc_deliver(exc_deliver),
        .ref_valid(ref_valid), .ref_seg(ref_seg), .view_seg(view_seg),
        .done(done), .fault(fault), .fault_code(fault_code), .view_sel(view_sel),
        .view_attr(view_attr), .int_inhibit(int_inhibit), .ref_fault(ref_fault)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive one load at a falling edge; outputs are sampled one falling edge later.
    task automatic load(input logic [2:0] seg, input logic [15:0] sel, input logic [1:0] pl,
                        input logic sn, input logic [3:0] kind, input logic [1:0] dpl,
                        input logic p, input logic [15:0] lim);
        @(negedge clk);
        req_valid = 1'b1; req_seg = seg; req_sel = sel; cpl = pl;
        desc_sys_n = sn; desc_kind = kind; desc_dpl = dpl; desc_present = p;
        tbl_limit = lim; view_seg = seg;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_result(input string tag, input logic [2:0] f, input logic [15:0] c,
                                 input logic [15:0] vs, input logic [7:0] va);
        check({tag, " done"}, done, 1'b1);
        check({tag, " fault"}, fault, f);
        check({tag, " code"}, fault_code, c);
        check({tag, " view_sel"}, view_sel, vs);
        check({tag, " view_attr"}, view_attr, va);
    endtask

    task automatic t_reset;
        check("R1 done", done, 1'b0);
        check("R1 inhibit", int_inhibit, 1'b0);
        check("R1 fault", fault, F_NONE);
        for (int i = 0; i < 6; i++) begin
            view_seg = 3'(i);
            #1;
            check("R1 sel", view_sel, 16'h0);
            check("R1 attr", view_attr, 8'h0);
        end
    endtask

    task automatic t_data_ok;
        load(3'd3, 16'h0013, 2'd3, 1'b1, 4'b0010, 2'd3, 1'b1, 16'h00FF);
        expect_result("R14 ds ok", F_NONE, 16'h0, 16'h0013, 8'hF2);
        @(negedge clk);
        check("R2 done drops", done, 1'b0);
    endtask

    task automatic t_null_data;
        load(3'd0, 16'h0003, 2'd3, 1'b0, 4'b0000, 2'd0, 1'b0, 16'h0000);
        expect_result("R3 null es", F_NONE, 16'h0, 16'h0003, 8'h00);
        ref_valid = 1'b1; ref_seg = 3'd0;
        @(negedge clk);
        check("R4 ref null", ref_fault, 1'b1);
        ref_seg = 3'd3;
        @(negedge clk);
        check("R4 ref ok", ref_fault, 1'b0);
        ref_valid = 1'b0;
    endtask

    task automatic t_ss_null;
        load(3'd2, 16'h0001, 2'd1, 1'b1, 4'b0010, 2'd1, 1'b1, 16'h00FF);
        expect_result("R5 ss null", F_GP, 16'h0, 16'h0000, 8'h00);
        check("R13 no inhibit", int_inhibit, 1'b0);
    endtask

    task automatic t_ss_good;
        load(3'd2, 16'h0020, 2'd0, 1'b1, 4'b0011, 2'd0, 1'b1, 16'h00FF);
        expect_result("R14 ss ok", F_NONE, 16'h0, 16'h0020, 8'h93);
        check("R13 set", int_inhibit, 1'b1);
        insn_retire = 1'b1;
        @(negedge clk);
        insn_retire = 1'b0;
        check("R13 retire clears", int_inhibit, 1'b0);
        load(3'd2, 16'h0020, 2'd0, 1'b1, 4'b0011, 2'd0, 1'b1, 16'h00FF);
        check("R13 set again", int_inhibit, 1'b1);
        exc_deliver = 1'b1;
        @(negedge clk);
        exc_deliver = 1'b0;
        check("R13 delivery clears", int_inhibit, 1'b0);
        insn_retire = 1'b1;
        load(3'd2, 16'h0020, 2'd0, 1'b1, 4'b0011, 2'd0, 1'b1, 16'h00FF);
        check("R13 set wins", int_inhibit, 1'b1);
        @(negedge clk);
        insn_retire = 1'b0;
        check("R13 cleared after", int_inhibit, 1'b0);
    endtask

    task automatic t_ss_gp;
        load(3'd2, 16'h0029, 2'd0, 1'b1, 4'b0010, 2'd0, 1'b1, 16'h00FF);
        expect_result("R6 rpl", F_GP, 16'h0029, 16'h0020, 8'h93);
        load(3'd2, 16'h0028, 2'd0, 1'b1, 4'b0000, 2'd0, 1'b1, 16'h00FF);
        expect_result("R6 readonly", F_GP, 16'h0028, 16'h0020, 8'h93);
        load(3'd2, 16'h0028, 2'd0, 1'b1, 4'b0010, 2'd1, 1'b1, 16'h00FF);
        expect_result("R6 dpl", F_GP, 16'h0028, 16'h0020, 8'h93);
        load(3'd2, 16'h0028, 2'd0, 1'b1, 4'b1010, 2'd0, 1'b1, 16'h00FF);
        expect_result("R6 code", F_GP, 16'h0028, 16'h0020, 8'h93);
        check("R13 faulting ss", int_inhibit, 1'b0);
    endtask

    task automatic t_limit;
        load(3'd2, 16'h0100, 2'd0, 1'b1, 4'b0010, 2'd0, 1'b1, 16'h0106);
        expect_result("R11 over", F_GP, 16'h0100, 16'h0020, 8'h93);
        load(3'd2, 16'h0100, 2'd0, 1'b1, 4'b0010, 2'd0, 1'b1, 16'h0107);
        expect_result("R11 equal", F_NONE, 16'h0, 16'h0100, 8'h92);
    endtask

    task automatic t_ss_np;
        load(3'd2, 16'h0030, 2'd0, 1'b1, 4'b0010, 2'd0, 1'b0, 16'h00FF);
        expect_result("R7 ss np", F_STK, 16'h0030, 16'h0100, 8'h92);
        load(3'd2, 16'h0030, 2'd0, 1'b1, 4'b0010, 2'd2, 1'b0, 16'h00FF);
        expect_result("R12 gp before np", F_GP, 16'h0030, 16'h0100, 8'h92);
    endtask

    task automatic t_data_gp;
        load(3'd4, 16'h0040, 2'd0, 1'b1, 4'b1000, 2'd0, 1'b1, 16'h00FF);
        expect_result("R8 exec only", F_GP, 16'h0040, 16'h0000, 8'h00);
        load(3'd4, 16'h0040, 2'd0, 1'b0, 4'b0010, 2'd0, 1'b1, 16'h00FF);
        expect_result("R8 system", F_GP, 16'h0040, 16'h0000, 8'h00);
        load(3'd4, 16'h0040, 2'd2, 1'b1, 4'b0010, 2'd1, 1'b1, 16'h00FF);
        expect_result("R8 cpl gt dpl", F_GP, 16'h0040, 16'h0000, 8'h00);
        load(3'd4, 16'h0043, 2'd2, 1'b1, 4'b0010, 2'd2, 1'b1, 16'h00FF);
        expect_result("R8 rpl gt dpl", F_GP, 16'h0043, 16'h0000, 8'h00);
        load(3'd4, 16'h0043, 2'd3, 1'b1, 4'b1010, 2'd0, 1'b1, 16'h00FF);
        expect_result("R8 nonconf code", F_GP, 16'h0043, 16'h0000, 8'h00);
        load(3'd4, 16'h0043, 2'd3, 1'b1, 4'b1110, 2'd0, 1'b1, 16'h00FF);
        expect_result("R8 conf code ok", F_NONE, 16'h0, 16'h0043, 8'h9E);
    endtask

    task automatic t_data_np;
        load(3'd5, 16'h0048, 2'd0, 1'b1, 4'b0010, 2'd0, 1'b0, 16'h00FF);
        expect_result("R9 np", F_NP, 16'h0048, 16'h0000, 8'h00);
        load(3'd5, 16'h0048, 2'd0, 1'b1, 4'b0010, 2'd0, 1'b0, 16'h0040);
        expect_result("R12 limit before np", F_GP, 16'h0048, 16'h0000, 8'h00);
    endtask

    task automatic t_ud;
        load(3'd1, 16'h0008, 2'd0, 1'b1, 4'b1010, 2'd0, 1'b1, 16'h00FF);
        expect_result("R10 cs", F_UD, 16'h0, 16'h0000, 8'h00);
        load(3'd6, 16'h0008, 2'd0, 1'b1, 4'b0010, 2'd0, 1'b1, 16'h00FF);
        check("R10 code6 fault", fault, F_UD);
        check("R10 code6 code", fault_code, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_data_ok();
        t_null_data();
        t_ss_null();
        t_ss_good();
        t_ss_gp();
        t_limit();
        t_ss_np();
        t_data_gp();
        t_data_np();
        t_ud();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule